// File: doc/BRIEF.md
# Register-Group Overlap Hazard Checker

This block sits at the issue point of a vector pipeline whose operands are runs of consecutive physical registers. Each operand is named by a 13-bit first-register number and a length that may be any count, not only a power of two. An instruction carries one destination run and two source runs. The checker holds a small table of instructions that have issued but not yet retired. It compares a presented instruction's runs against every live table slot and decides in the same cycle whether that instruction may issue.

Each table slot is a two-state machine. SLOT_FREE moves to SLOT_BUSY on an allocate. SLOT_BUSY moves back to SLOT_FREE on a retire carrying its tag. A SLOT_BUSY slot that retires and is allocated in the same cycle stays in SLOT_BUSY and takes the new runs (reload). On issue the checker hands back the tag of the slot it allocated, and the execution side later presents that tag on the retire port.

A run is encoded as a head `h` and a field `m` holding the register count minus one. It covers the registers h through h+m, with the end computed one bit wider than the head so it never wraps.

Top module: `vgrp_hazard_top`

## Requirements
- R1: After reset every slot is SLOT_FREE. With nothing presented, stall, issue, sb_full and all hazard outputs are low, and the first instruction issues with tag 0.
- R2: Runs [a, a+ma] and [b, b+mb] conflict exactly when a <= b+mb and b <= a+ma. Both ends are inclusive, and the end is computed in 14 bits without wrap.
- R3: haz_raw is high when either presented source run overlaps the destination run of a live slot.
- R4: haz_waw is high when the presented destination run overlaps the destination run of a live slot.
- R5: haz_war is high when the presented destination run overlaps either source run of a live slot.
- R6: issue = in_valid and not stall. On issue, the lowest-numbered slot that is free (or retiring in that cycle) is allocated, its number appears on issue_tag in the same cycle, and it is live from the next cycle.
- R7: A retire with tag t frees slot t at the next edge. In the retire cycle, slot t is already left out of the comparisons, so an instruction that depends only on it issues in that same cycle.
- R8: When all slots are busy and none retires, sb_full is high and a presented instruction stalls even with no overlap. A retire in the same cycle lets it issue into the retiring slot.
- R9: A retire naming a slot that is SLOT_FREE changes nothing: that slot stays free and can still be allocated.
- R10: stall and the three hazard outputs are combinational in the presented instruction and the table, and all four are low whenever in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_dst_head | input | 13 | Destination run first register |
| in_dst_lenm1 | input | 6 | Destination run count minus one |
| in_src1_head | input | 13 | First source run first register |
| in_src1_lenm1 | input | 6 | First source run count minus one |
| in_src2_head | input | 13 | Second source run first register |
| in_src2_lenm1 | input | 6 | Second source run count minus one |
| retire_valid | input | 1 | A slot retires this cycle |
| retire_tag | input | 2 | Tag of the retiring slot |
| stall | output | 1 | Presented instruction must wait |
| issue | output | 1 | Presented instruction issues this cycle |
| issue_tag | output | 2 | Slot allocated on issue |
| sb_full | output | 1 | No slot free or retiring |
| haz_raw | output | 1 | Source overlaps a live destination |
| haz_waw | output | 1 | Destination overlaps a live destination |
| haz_war | output | 1 | Destination overlaps a live source |

## Verification
stall, issue, issue_tag, sb_full and the hazard flags are due in the same cycle as the presented instruction and retire. The bench drives on the falling edge and samples these outputs 1 ns later, before the next rising edge. A change in slot state (allocate or free) only appears after the following rising edge. It is therefore observed by presenting a new instruction at the next falling edge and reading which tag issues or whether a stall appears.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;
    localparam int HEAD_W = 13;
    localparam int LEN_W  = 6;
    localparam int END_W  = HEAD_W + 1;

    typedef logic [HEAD_W-1:0] head_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        head_t head;
        len_t  lenm1;
    } grp_t;

    typedef struct packed {
        grp_t dst;
        grp_t src1;
        grp_t src2;
    } instr_t;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;
endpackage

// File: rtl/vgrp_overlap.sv
module vgrp_overlap
    import vgrp_pkg::*;
(
    input  grp_t a,
    input  grp_t b,
    output logic hit
);
    logic [END_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = END_W'(a.head);
        b_lo = END_W'(b.head);
        a_hi = END_W'(a.head) + END_W'(a.lenm1);
        b_hi = END_W'(b.head) + END_W'(b.lenm1);
        hit  = (a_lo <= b_hi) && (b_lo <= a_hi);
    end
endmodule

// File: rtl/vgrp_slot.sv
module vgrp_slot
    import vgrp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  logic   retire,
    input  instr_t load_instr,
    output logic   busy,
    output instr_t held
);
    slot_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SLOT_FREE: if (load) state_nxt = SLOT_BUSY;
            SLOT_BUSY: begin
                if (load)        state_nxt = SLOT_BUSY;
                else if (retire) state_nxt = SLOT_FREE;
            end
            default:             state_nxt = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SLOT_FREE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= load_instr;
    end

    always_comb begin
        busy = (state == SLOT_BUSY);
    end
endmodule

// File: rtl/vgrp_alloc.sv
module vgrp_alloc #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input  logic [DEPTH-1:0] free_vec,
    output logic             any_free,
    output logic [TAG_W-1:0] pick
);
    always_comb begin
        any_free = 1'b0;
        pick     = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                any_free = 1'b1;
                pick     = TAG_W'(i);
            end
        end
    end
endmodule

// File: rtl/vgrp_hazard_top.sv
module vgrp_hazard_top
    import vgrp_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HEAD_W-1:0] in_dst_head,
    input  logic [LEN_W-1:0]  in_dst_lenm1,
    input  logic [HEAD_W-1:0] in_src1_head,
    input  logic [LEN_W-1:0]  in_src1_lenm1,
    input  logic [HEAD_W-1:0] in_src2_head,
    input  logic [LEN_W-1:0]  in_src2_lenm1,
    input  logic              retire_valid,
    input  logic [TAG_W-1:0]  retire_tag,
    output logic              stall,
    output logic              issue,
    output logic [TAG_W-1:0]  issue_tag,
    output logic              sb_full,
    output logic              haz_raw,
    output logic              haz_waw,
    output logic              haz_war
);
    instr_t           cur;
    logic [DEPTH-1:0] slot_busy, retiring, live, free_vec, load;
    logic [DEPTH-1:0] raw_vec, waw_vec, war_vec;
    logic             any_free;
    logic [TAG_W-1:0] pick;

    always_comb begin
        cur.dst.head   = in_dst_head;
        cur.dst.lenm1  = in_dst_lenm1;
        cur.src1.head  = in_src1_head;
        cur.src1.lenm1 = in_src1_lenm1;
        cur.src2.head  = in_src2_head;
        cur.src2.lenm1 = in_src2_lenm1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        instr_t held;
        logic   h_s1d, h_s2d, h_dd, h_dd1, h_dd2;

        assign retiring[g] = retire_valid && (retire_tag == TAG_W'(g));
        assign live[g]     = slot_busy[g] && !retiring[g];
        assign free_vec[g] = !live[g];
        assign load[g]     = issue && (pick == TAG_W'(g));

        vgrp_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load[g]),
            .retire     (retiring[g]),
            .load_instr (cur),
            .busy       (slot_busy[g]),
            .held       (held)
        );

        vgrp_overlap u_s1d (.a(cur.src1), .b(held.dst),  .hit(h_s1d));
        vgrp_overlap u_s2d (.a(cur.src2), .b(held.dst),  .hit(h_s2d));
        vgrp_overlap u_dd  (.a(cur.dst),  .b(held.dst),  .hit(h_dd));
        vgrp_overlap u_dd1 (.a(cur.dst),  .b(held.src1), .hit(h_dd1));
        vgrp_overlap u_dd2 (.a(cur.dst),  .b(held.src2), .hit(h_dd2));

        assign raw_vec[g] = live[g] && (h_s1d || h_s2d);
        assign waw_vec[g] = live[g] && h_dd;
        assign war_vec[g] = live[g] && (h_dd1 || h_dd2);
    end

    vgrp_alloc #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_alloc (
        .free_vec (free_vec),
        .any_free (any_free),
        .pick     (pick)
    );

    always_comb begin
        sb_full   = !any_free;
        haz_raw   = in_valid && (|raw_vec);
        haz_waw   = in_valid && (|waw_vec);
        haz_war   = in_valid && (|war_vec);
        stall     = in_valid && (sb_full || haz_raw || haz_waw || haz_war);
        issue     = in_valid && !stall;
        issue_tag = pick;
    end
endmodule

// File: rtl/vgrp_hazard_chk.sv
module vgrp_hazard_chk #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             retire_valid,
    input logic [TAG_W-1:0] retire_tag,
    input logic             stall,
    input logic             issue,
    input logic [TAG_W-1:0] issue_tag,
    input logic             sb_full,
    input logic             haz_raw,
    input logic             haz_waw,
    input logic             haz_war,
    input logic [DEPTH-1:0] slot_busy
);
    p_alloc_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> slot_busy[$past(issue_tag)]);

    p_pick_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!slot_busy[issue_tag] || (retire_valid && retire_tag == issue_tag)));

    p_retire_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !(issue && issue_tag == retire_tag)) |=> !slot_busy[$past(retire_tag)]);

    p_full_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&slot_busy) && !retire_valid) |-> (stall && sb_full));

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !retire_valid) |=> $stable(slot_busy));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!stall && !issue && !haz_raw && !haz_waw && !haz_war));

    p_hazard_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (haz_raw || haz_waw || haz_war) |-> !issue);
endmodule

bind vgrp_hazard_top vgrp_hazard_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .retire_valid (retire_valid),
    .retire_tag   (retire_tag),
    .stall        (stall),
    .issue        (issue),
    .issue_tag    (issue_tag),
    .sb_full      (sb_full),
    .haz_raw      (haz_raw),
    .haz_waw      (haz_waw),
    .haz_war      (haz_war),
    .slot_busy    (slot_busy)
);

// File: tb/sim_vgrp_hazard_top.sv
module sim_vgrp_hazard_top;
    import vgrp_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [HEAD_W-1:0] in_dst_head = '0, in_src1_head = '0, in_src2_head = '0;
    logic [LEN_W-1:0]  in_dst_lenm1 = '0, in_src1_lenm1 = '0, in_src2_lenm1 = '0;
    logic              retire_valid = 1'b0;
    logic [1:0]        retire_tag = '0;
    logic              stall, issue, sb_full, haz_raw, haz_waw, haz_war;
    logic [1:0]        issue_tag;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    vgrp_hazard_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_dst_head(in_dst_head), .in_dst_lenm1(in_dst_lenm1),
        .in_src1_head(in_src1_head), .in_src1_lenm1(in_src1_lenm1),
        .in_src2_head(in_src2_head), .in_src2_lenm1(in_src2_lenm1),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .stall(stall), .issue(issue), .issue_tag(issue_tag), .sb_full(sb_full),
        .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war)
    );

    typedef struct packed {
        int od, odl, o1, o1l, o2, o2l;
        int nd, ndl, n1, n1l, n2, n2l;
        bit raw, waw, war;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{100, 3, 500, 0, 600, 0, 200, 0, 103, 0, 300, 0, 1, 0, 0},
        '{100, 3, 500, 0, 600, 0, 200, 0, 104, 0,  99, 0, 0, 0, 0},
        '{100, 3, 500, 0, 600, 0, 200, 0, 300, 0,  99, 1, 1, 0, 0},
        '{100, 3, 500, 0, 600, 0, 102, 9, 300, 0, 301, 0, 0, 1, 0},
        '{100, 3, 500, 4, 600, 0, 504, 0, 300, 0, 301, 0, 0, 0, 1},
        '{100, 3, 500, 0, 600, 2, 590, 9, 300, 0, 301, 0, 0, 0, 0},
        '{100, 3, 500, 0, 600, 2, 590,10, 300, 0, 301, 0, 0, 0, 1},
        '{100, 3, 500, 0, 600, 0, 101, 0, 101, 0, 300, 0, 1, 1, 0},
        '{8190,5, 500, 0, 600, 0, 200, 0,   0, 0,8191, 0, 1, 0, 0},
        '{100, 3, 500, 0, 600, 0, 200, 0,  96, 9, 300, 0, 1, 0, 0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic present(input bit v, input int d, input int dl, input int s1,
                           input int s1l, input int s2, input int s2l);
        in_valid      = v;
        in_dst_head   = HEAD_W'(d);
        in_dst_lenm1  = LEN_W'(dl);
        in_src1_head  = HEAD_W'(s1);
        in_src1_lenm1 = LEN_W'(s1l);
        in_src2_head  = HEAD_W'(s2);
        in_src2_lenm1 = LEN_W'(s2l);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        in_valid     = 1'b0;
        retire_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #400000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 / R10: reset state with nothing presented
        chk("R1 stall", int'(stall), 0);
        chk("R1 issue", int'(issue), 0);
        chk("R1 sb_full", int'(sb_full), 0);
        chk("R10 flags", int'({haz_raw, haz_waw, haz_war}), 0);

        // Table walk: one live instruction, then a probe
        for (int i = 0; i < NV; i++) begin
            present(1, VT[i].od, VT[i].odl, VT[i].o1, VT[i].o1l, VT[i].o2, VT[i].o2l);
            #1;
            chk("R6 table issue", int'(issue), 1);
            chk("R1 table tag", int'(issue_tag), 0);
            step();
            present(1, VT[i].nd, VT[i].ndl, VT[i].n1, VT[i].n1l, VT[i].n2, VT[i].n2l);
            #1;
            chk("R3 raw", int'(haz_raw), int'(VT[i].raw));
            chk("R4 waw", int'(haz_waw), int'(VT[i].waw));
            chk("R5 war", int'(haz_war), int'(VT[i].war));
            chk("R2 stall", int'(stall), int'(VT[i].raw | VT[i].waw | VT[i].war));
            in_valid     = 1'b0;
            retire_valid = 1'b1;
            retire_tag   = 2'd0;
            step();
        end

        // R6: fill all slots with independent instructions
        for (int k = 0; k < 4; k++) begin
            present(1, 1000 + 16 * k, 3, 2000 + 16 * k, 0, 2008 + 16 * k, 0);
            #1;
            chk("R6 fill tag", int'(issue_tag), k);
            chk("R6 fill issue", int'(issue), 1);
            step();
        end

        // R8: full without overlap
        present(1, 3000, 0, 3100, 0, 3200, 0);
        #1;
        chk("R8 full stall", int'(stall), 1);
        chk("R8 sb_full", int'(sb_full), 1);
        chk("R8 no overlap", int'({haz_raw, haz_waw, haz_war}), 0);
        // R8: same-cycle retire opens slot 2
        retire_valid = 1'b1;
        retire_tag   = 2'd2;
        #1;
        chk("R8 retire issue", int'(issue), 1);
        chk("R8 retire tag", int'(issue_tag), 2);
        step();

        // free slot 3, then probe dependence on slot 1 destination
        retire_valid = 1'b1;
        retire_tag   = 2'd3;
        step();
        present(1, 3300, 0, 1016, 0, 3400, 0);
        #1;
        chk("R3 not full", int'(sb_full), 0);
        chk("R3 dep stall", int'(stall), 1);
        chk("R3 dep raw", int'(haz_raw), 1);
        in_valid     = 1'b0;
        retire_valid = 1'b1;
        retire_tag   = 2'd1;
        step();
        present(1, 3300, 0, 1016, 0, 3400, 0);
        #1;
        chk("R7 after retire issue", int'(issue), 1);
        chk("R7 after retire tag", int'(issue_tag), 1);
        step();

        // R9: retire of free slot 3 leaves it free
        retire_valid = 1'b1;
        retire_tag   = 2'd3;
        step();
        present(1, 3500, 0, 3600, 0, 3700, 0);
        #1;
        chk("R9 free slot issue", int'(issue), 1);
        chk("R9 free slot tag", int'(issue_tag), 3);
        step();

        // R7: dependence on slot 0 while slot 0 retires in the same cycle
        present(1, 3800, 0, 1000, 0, 3900, 0);
        #1;
        chk("R7 before retire stall", int'(stall), 1);
        retire_valid = 1'b1;
        retire_tag   = 2'd0;
        #1;
        chk("R7 bypass stall", int'(stall), 0);
        chk("R7 bypass tag", int'(issue_tag), 0);
        chk("R7 bypass raw", int'(haz_raw), 0);
        step();

        // R10: overlapping operands with in_valid low
        present(0, 3800, 0, 3000, 0, 3500, 0);
        #1;
        chk("R10 idle stall", int'(stall), 0);
        chk("R10 idle flags", int'({haz_raw, haz_waw, haz_war}), 0);
        chk("R10 idle issue", int'(issue), 0);

        summary();
        $finish;
    end
endmodule